// File: doc/BRIEF.md
# Single-Packet Stream Flow Controller

This block sits on one input of a tile's communication interface and manages the words arriving from a neighbouring tile. Every stream has exactly one packet of storage, held in a small data memory. Each slot carries a flag that says whether it holds a word. A word that arrives on a cycle where the schedule sends its stream is passed straight to the crossbar. Otherwise the word is parked in its stream's slot if that slot is free. If the slot is occupied, the word is refused and the sender keeps it.

On each cycle the schedule names one stream to send. The block picks the crossbar source with a 2:1 choice. Stored data always wins over a live word of the same stream. The block also raises the acknowledge to the sender and refuses any send of a stream that was sent on the cycle before. A slot is released only by an explicit clear from the receiving side.

Top module: `spfc_stream_flow_ctrl`

## Requirements
- R1: After reset every slot is empty, so a send request with no live word produces no output (`out_vld_o`=0).
- R2: When a send of stream S is allowed, slot S is empty and a live word of stream S is present, the live word goes out in the same cycle with `out_src_o`=0 and `in_ack_o`=1. Slot S stays empty.
- R3: A live word that is not forwarded is written into its stream's slot when that slot is empty, with `in_ack_o`=1 in that cycle. A later allowed send of the stream outputs that word with `out_src_o`=1.
- R4: A live word whose stream slot already holds a word, and which is not forwarded, gets `in_ack_o`=0 and leaves the slot contents unchanged.
- R5: When the slot of the scheduled stream holds a word, an allowed send outputs the stored word (`out_src_o`=1), even if a live word of the same stream is present.
- R6: A send and an acknowledge of a different stream's word can both happen in the same cycle.
- R7: A send request naming the stream actually sent on the previous cycle is suppressed (`out_vld_o`=0) and raises `err_o`=1. A suppressed request does not count as a send.
- R8: A clear of an occupied slot empties it from the next cycle on. A clear of an empty slot does nothing, and a write in the same cycle is kept.
- R9: A stored word stays in its slot across sends until it is cleared, so it can be sent again on a later, non-adjacent cycle.
- R10: `err_o` is 0 on every cycle without a suppressed send request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_vld_i | input | 1 | Live word from the neighbour is present |
| in_sid_i | input | 3 | Stream of the live word (write address from schedule) |
| in_data_i | input | 32 | Live word |
| in_ack_o | output | 1 | Live word accepted (forwarded or stored) |
| snd_req_i | input | 1 | Schedule requests a send this cycle |
| snd_sid_i | input | 3 | Stream to send (read address from schedule) |
| clr_i | input | 1 | Clear from the receiving side |
| clr_sid_i | input | 3 | Stream slot to clear |
| out_vld_o | output | 1 | Word is driven to the crossbar |
| out_src_o | output | 1 | 1 = stored word, 0 = live word |
| out_data_o | output | 32 | Word to the crossbar |
| err_o | output | 1 | Send request suppressed by the back-to-back rule |

## Verification
The assertions assume that the stream indices are known whenever their qualifying valid or request bit is high. They also assume that reset is applied before the first checked edge. The bench drives every input with a defined value on each cycle, and all indices stay inside the eight streams. The random mix repeats send streams often enough to hit the back-to-back rule, and it clears slots sparsely so that slots stay occupied long enough for refused words to appear.

// File: rtl/spfc_pkg.sv
package spfc_pkg;
   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } src_e;
endpackage

// File: rtl/spfc_slot_buf.sv
module spfc_slot_buf #(
   parameter int DATA_W    = 32,
   parameter int NUM_SLOTS = 8,
   localparam int SID_W    = $clog2(NUM_SLOTS)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 wr_en_i,
   input  logic [SID_W-1:0]     wr_sid_i,
   input  logic [DATA_W-1:0]    wr_data_i,
   input  logic                 clr_en_i,
   input  logic [SID_W-1:0]     clr_sid_i,
   input  logic [SID_W-1:0]     rd_sid_i,
   output logic [DATA_W-1:0]    rd_data_o,
   output logic [NUM_SLOTS-1:0] vld_o
);
   logic [DATA_W-1:0]    data_q [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] vld_q;

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic wr_here, clr_here;
      assign wr_here  = wr_en_i  && (wr_sid_i  == SID_W'(g));
      assign clr_here = clr_en_i && (clr_sid_i == SID_W'(g));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            vld_q[g]  <= 1'b0;
            data_q[g] <= '0;
         end else begin
            if (wr_here) begin
               vld_q[g]  <= 1'b1;
               data_q[g] <= wr_data_i;
            end else if (clr_here) begin
               vld_q[g]  <= 1'b0;
            end
         end
      end

      // R9: an occupied slot not being cleared keeps its word
      p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (vld_q[g] && !clr_here) |=> (vld_q[g] && $stable(data_q[g])))
         else $error("slot %0d lost its word", g);

      // R8: clearing an occupied slot empties it
      p_clear_frees_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (vld_q[g] && clr_here) |=> !vld_q[g])
         else $error("slot %0d not freed by clear", g);
   end

   assign rd_data_o = data_q[rd_sid_i];
   assign vld_o     = vld_q;

   // R4: a write never lands on an occupied slot
   p_no_overwrite_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |-> !vld_q[wr_sid_i])
      else $error("write into occupied slot");

   // R1: slots are empty on the first edge after reset release
   p_reset_empty_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (vld_q == '0))
      else $error("slots not empty after reset");
endmodule

// File: rtl/spfc_repeat_guard.sv
module spfc_repeat_guard #(
   parameter int NUM_SLOTS = 8,
   localparam int SID_W    = $clog2(NUM_SLOTS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             req_i,
   input  logic [SID_W-1:0] sid_i,
   input  logic             fire_i,
   output logic             block_o
);
   logic             last_vld_q;
   logic [SID_W-1:0] last_sid_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         last_vld_q <= 1'b0;
         last_sid_q <= '0;
      end else begin
         last_vld_q <= fire_i;
         last_sid_q <= sid_i;
      end
   end

   assign block_o = req_i && last_vld_q && (last_sid_q == sid_i);
endmodule

// File: rtl/spfc_out_mux.sv
module spfc_out_mux #(
   parameter int DATA_W = 32
) (
   input  spfc_pkg::src_e    sel_i,
   input  logic [DATA_W-1:0] live_i,
   input  logic [DATA_W-1:0] stored_i,
   output logic [DATA_W-1:0] data_o
);
   always_comb begin
      unique case (sel_i)
         spfc_pkg::SRC_STORED: data_o = stored_i;
         default:              data_o = live_i;
      endcase
   end
endmodule

// File: rtl/spfc_stream_flow_ctrl.sv
module spfc_stream_flow_ctrl #(
   parameter int DATA_W      = 32,
   parameter int NUM_STREAMS = 8,
   localparam int SID_W      = $clog2(NUM_STREAMS)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              in_vld_i,
   input  logic [SID_W-1:0]  in_sid_i,
   input  logic [DATA_W-1:0] in_data_i,
   output logic              in_ack_o,
   input  logic              snd_req_i,
   input  logic [SID_W-1:0]  snd_sid_i,
   input  logic              clr_i,
   input  logic [SID_W-1:0]  clr_sid_i,
   output logic              out_vld_o,
   output logic              out_src_o,
   output logic [DATA_W-1:0] out_data_o,
   output logic              err_o
);
   import spfc_pkg::*;

   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (NUM_STREAMS < 2 || (NUM_STREAMS & (NUM_STREAMS - 1)) != 0) begin : g_bad_streams
      $error("NUM_STREAMS must be a power of two, at least 2");
   end

   logic [NUM_STREAMS-1:0] slot_vld;
   logic [DATA_W-1:0]      stored_data;
   logic                   blocked, send_ok, slot_hit, in_busy;
   logic                   fwd, fire, wr_en;
   src_e                   src_sel;

   spfc_slot_buf #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_STREAMS)) buf_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en),
      .wr_sid_i (in_sid_i),
      .wr_data_i(in_data_i),
      .clr_en_i (clr_i),
      .clr_sid_i(clr_sid_i),
      .rd_sid_i (snd_sid_i),
      .rd_data_o(stored_data),
      .vld_o    (slot_vld)
   );

   spfc_repeat_guard #(.NUM_SLOTS(NUM_STREAMS)) guard_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (snd_req_i),
      .sid_i  (snd_sid_i),
      .fire_i (fire),
      .block_o(blocked)
   );

   assign slot_hit = slot_vld[snd_sid_i];
   assign in_busy  = slot_vld[in_sid_i];
   assign send_ok  = snd_req_i && !blocked;
   assign fwd      = send_ok && in_vld_i && (in_sid_i == snd_sid_i) && !slot_hit;
   assign fire     = send_ok && (slot_hit || fwd);
   assign wr_en    = in_vld_i && !fwd && !in_busy;
   assign src_sel  = slot_hit ? SRC_STORED : SRC_LIVE;

   spfc_out_mux #(.DATA_W(DATA_W)) mux_i (
      .sel_i   (src_sel),
      .live_i  (in_data_i),
      .stored_i(stored_data),
      .data_o  (out_data_o)
   );

   assign in_ack_o  = fwd || wr_en;
   assign out_vld_o = fire;
   assign out_src_o = src_sel;
   assign err_o     = snd_req_i && blocked;

   // R7: no stream leaves on two adjacent cycles
   p_no_repeat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_vld_o && $past(out_vld_o)) |-> (snd_sid_i != $past(snd_sid_i)))
      else $error("stream sent on two adjacent cycles");

   // R5: an occupied slot is always drained ahead of live data
   p_stored_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_vld_o && slot_vld[snd_sid_i]) |-> (out_src_o == 1'b1))
      else $error("live word overtook stored word");

   // R3: an acknowledged word not sent on is held in its slot next cycle
   p_ack_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_ack_o && !(out_vld_o && out_src_o == 1'b0)) |=> slot_vld[$past(in_sid_i)])
      else $error("acknowledged word was dropped");

   // R10: error only with a send request
   p_err_needs_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> (snd_req_i && !out_vld_o))
      else $error("error flag without suppressed request");
endmodule

// File: tb/spfc_stream_flow_ctrl_tb_top.sv
module spfc_stream_flow_ctrl_tb_top;
   localparam int DW = 32;
   localparam int NS = 8;
   localparam int SW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_vld = 1'b0, snd_req = 1'b0, clr = 1'b0;
   logic [SW-1:0] in_sid = '0, snd_sid = '0, clr_sid = '0;
   logic [DW-1:0] in_data = '0;
   logic          in_ack, out_vld, out_src, err;
   logic [DW-1:0] out_data;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference state
   logic          m_vld [NS];
   logic [DW-1:0] m_mem [NS];
   logic          m_last_v;
   logic [SW-1:0] m_last_sid;

   always #5 clk = ~clk;

   spfc_stream_flow_ctrl #(.DATA_W(DW), .NUM_STREAMS(NS)) dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .in_vld_i(in_vld), .in_sid_i(in_sid), .in_data_i(in_data), .in_ack_o(in_ack),
      .snd_req_i(snd_req), .snd_sid_i(snd_sid),
      .clr_i(clr), .clr_sid_i(clr_sid),
      .out_vld_o(out_vld), .out_src_o(out_src), .out_data_o(out_data), .err_o(err)
   );

   task automatic chk(input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic string pick(input string ovr, input string dflt);
      return (ovr.len() != 0) ? ovr : dflt;
   endfunction

   // one cycle: drive at negedge, check after settling, advance model
   task automatic step(input logic s, input logic [SW-1:0] ss,
                       input logic iv, input logic [SW-1:0] is, input logic [DW-1:0] id,
                       input logic c, input logic [SW-1:0] cs, input string tag);
      logic hit, blk, ok, fw, fire_e, wr, ack_e;
      logic [DW-1:0] dat_e;
      @(negedge clk);
      snd_req = s; snd_sid = ss; in_vld = iv; in_sid = is; in_data = id;
      clr = c; clr_sid = cs;
      #1;
      hit    = m_vld[ss];
      blk    = s && m_last_v && (m_last_sid == ss);
      ok     = s && !blk;
      fw     = ok && iv && (is == ss) && !hit;
      fire_e = ok && (hit || fw);
      wr     = iv && !fw && !m_vld[is];
      ack_e  = fw || wr;
      dat_e  = hit ? m_mem[ss] : id;
      chk(pick(tag, blk ? "R7" : (hit ? "R5" : "R2")), "out_vld", 32'(out_vld), 32'(fire_e));
      if (fire_e) begin
         chk(pick(tag, hit ? "R5" : "R2"), "out_src", 32'(out_src), 32'(hit));
         chk(pick(tag, hit ? "R3" : "R2"), "out_data", out_data, dat_e);
      end
      chk(pick(tag, wr ? "R3" : (fw ? "R2" : "R4")), "in_ack", 32'(in_ack), 32'(ack_e));
      chk(pick(tag, blk ? "R7" : "R10"), "err", 32'(err), 32'(blk));
      if (wr) begin
         m_vld[is] = 1'b1;
         m_mem[is] = id;
      end
      if (c && !(wr && cs == is)) m_vld[cs] = 1'b0;
      m_last_v   = fire_e;
      m_last_sid = ss;
   endtask

   task automatic idle();
      step(1'b0, '0, 1'b0, '0, '0, 1'b0, '0, "");
   endtask

   initial begin
      for (int i = 0; i < NS; i++) begin
         m_vld[i] = 1'b0;
         m_mem[i] = '0;
      end
      m_last_v = 1'b0;
      m_last_sid = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: every stream empty after reset
      for (int i = 0; i < NS; i++) step(1'b1, SW'(i), 1'b0, '0, '0, 1'b0, '0, "R1");
      idle();
      // R2: forward live word
      step(1'b1, 3'd1, 1'b1, 3'd1, 32'hA1A1_0001, 1'b0, '0, "R2");
      idle();
      // R3: park word, then send it from the slot
      step(1'b0, '0, 1'b1, 3'd2, 32'hB2B2_0002, 1'b0, '0, "R3");
      step(1'b1, 3'd2, 1'b0, '0, '0, 1'b0, '0, "R3");
      idle();
      // R4: occupied slot refuses a new word
      step(1'b0, '0, 1'b1, 3'd2, 32'hC3C3_0003, 1'b0, '0, "R4");
      // R5: stored word beats live word of the same stream
      step(1'b1, 3'd2, 1'b1, 3'd2, 32'hD4D4_0004, 1'b0, '0, "R5");
      // R7: same stream on the next cycle is suppressed
      step(1'b1, 3'd2, 1'b0, '0, '0, 1'b0, '0, "R7");
      // R9: still stored, can go again now
      step(1'b1, 3'd2, 1'b0, '0, '0, 1'b0, '0, "R9");
      // R6: send stream 2 from store while storing stream 5
      step(1'b1, 3'd3, 1'b0, '0, '0, 1'b0, '0, "");
      step(1'b1, 3'd2, 1'b1, 3'd5, 32'hE5E5_0005, 1'b0, '0, "R6");
      // R8: clear slot 2, then a send finds it empty
      step(1'b0, '0, 1'b0, '0, '0, 1'b1, 3'd2, "R8");
      step(1'b1, 3'd2, 1'b0, '0, '0, 1'b0, '0, "R8");
      // R8: clear of empty slot with simultaneous write keeps the write
      step(1'b0, '0, 1'b1, 3'd6, 32'hF6F6_0006, 1'b1, 3'd6, "R8");
      step(1'b1, 3'd6, 1'b0, '0, '0, 1'b0, '0, "R8");
      step(1'b0, '0, 1'b0, '0, '0, 1'b1, 3'd6, "R8");
      step(1'b0, '0, 1'b0, '0, '0, 1'b1, 3'd5, "R8");

      // constrained random mix
      begin
         int unsigned seed = 32'd7;
         void'($urandom(seed));
         for (int n = 0; n < 3000; n++) begin
            logic s, iv, c;
            logic [SW-1:0] ss, is, cs;
            logic [DW-1:0] id;
            s  = ($urandom % 4) != 0;
            ss = SW'(($urandom % 4 == 0) ? m_last_sid : SW'($urandom));
            iv = ($urandom % 3) != 0;
            is = ($urandom % 2 == 0) ? ss : SW'($urandom);
            id = $urandom;
            c  = ($urandom % 5) == 0;
            cs = SW'($urandom);
            step(s, ss, iv, is, id, c, cs, "");
         end
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule